// File: doc/BRIEF.md
# Single-Cycle Accumulator-Free Register Machine

This block is a very small processor core with eight 16-bit general registers. The highest register, R7, is also the program counter. Each clock cycle the core takes one instruction from a synchronous instruction memory and fully executes it. There are four operations: load an immediate, copy a register, subtract, and copy only when the last difference was nonzero. There is no branch instruction. Control flow comes from writing R7. To build a loop, a program copies R7 into a spare register before the loop body. At the bottom of the loop, a conditional copy puts that saved value back into R7.

The core drives the instruction-memory address combinationally with the address of the next instruction. The memory registers that address at the clock edge and returns the word one cycle later. That word is exactly the instruction R7 points at after the edge. A flattened view of all eight registers and the zero flag is brought out for observation.

Top module: `rfc_core`

## Requirements
- R1: While `rst` is high at a clock edge, every register and the zero flag are cleared. While `rst` is high, `imem_addr` is 0, so the first instruction after reset comes from address 0.
- R2: Instruction word layout: bits [15:13] opcode, [12:10] destination register d, [9:7] source register s, [6:0] immediate, zero-extended to 16 bits. Opcodes: 000 copy, 001 load-immediate, 010 subtract, 011 conditional copy, 100 to 111 no operation.
- R3: Load-immediate writes the zero-extended immediate into register d.
- R4: Copy writes the value of register s into register d. Reading R7 as a source yields the address of the instruction after the current one.
- R5: Subtract writes d - s (modulo 2^16) into d. It sets the zero flag to 1 exactly when that result is 0. No other opcode changes the zero flag.
- R6: Conditional copy writes register s into d only when the zero flag is 0. Otherwise no register changes and R7 advances by one.
- R7: After an instruction that does not write R7, R7 holds its old value plus one. After any write to R7 (copy, load-immediate, subtract, or a taken conditional copy), R7 holds the written value, and execution continues from that address.
- R8: One instruction completes per clock. The address on `imem_addr` in a cycle equals the value R7 holds after the next clock edge.
- R9: Opcodes 100 to 111 change no register other than advancing R7, and do not change the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Address of the next instruction to fetch |
| imem_rdata | input | 16 | Instruction word returned by the synchronous memory, one cycle after its address |
| dbg_regs | output | 128 | All registers, register i at bits [16*i+15:16*i] |
| dbg_zero | output | 1 | Current zero flag |

## Verification
A straight-line program exercises each opcode with distinct operand patterns: a positive difference, a zero difference, a wrapping negative difference, and the largest immediate. Together these separate correct subtraction and flag behaviour from sign or width slips. The conditional copy is run with the flag both set and clear, including straight after reset. This distinguishes a correctly gated write from one that always or never happens. A loop with a saved R7, a load-immediate jump over dead code, and a subtract whose destination is R7 check that a written program counter wins over the increment. They also check that R7 reads as the following address. A reserved opcode checks that only the program counter moves.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  localparam int NREG   = 8;
  localparam int RIW    = 3;
  localparam int OPW    = 3;
  localparam int PC_IDX = NREG - 1;

  typedef enum logic [OPW-1:0] {
    OP_MV    = 3'd0,
    OP_MVI   = 3'd1,
    OP_SUB   = 3'd2,
    OP_MVNZ  = 3'd3,
    OP_RSV4  = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } opcode_e;

  typedef struct packed {
    opcode_e        op;
    logic [RIW-1:0] rd;
    logic [RIW-1:0] rs;
  } fields_t;

endpackage

// File: rtl/rfc_decode.sv
module rfc_decode
  import rfc_pkg::*;
#(
  parameter int IW = 16,
  parameter int DW = 16
) (
  input  logic [IW-1:0] instr,
  output fields_t       fld,
  output logic [DW-1:0] imm_ext
);

  localparam int IMW = IW - OPW - 2 * RIW;

  logic [IMW-1:0] imm_raw;

  // R2: opcode on top, then destination, source, immediate in the low bits
  always_comb begin
    fld.op  = opcode_e'(instr[IW-1 -: OPW]);
    fld.rd  = instr[IW-OPW-1 -: RIW];
    fld.rs  = instr[IW-OPW-RIW-1 -: RIW];
    imm_raw = instr[IMW-1:0];
    imm_ext = {{(DW-IMW){1'b0}}, imm_raw};
  end

endmodule

// File: rtl/rfc_exec.sv
module rfc_exec
  import rfc_pkg::*;
#(
  parameter int DW = 16
) (
  input  opcode_e       op,
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] imm_ext,
  input  logic          zero_q,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          zero_we,
  output logic          zero_d
);

  logic [DW-1:0] diff;

  always_comb begin
    diff    = rd_val - rs_val;
    wr_en   = 1'b0;
    wr_data = '0;
    zero_we = 1'b0;
    zero_d  = 1'b0;
    unique case (op)
      OP_MV: begin
        wr_en   = 1'b1;
        wr_data = rs_val;
      end
      OP_MVI: begin
        wr_en   = 1'b1;
        wr_data = imm_ext;
      end
      OP_SUB: begin
        wr_en   = 1'b1;
        wr_data = diff;
        zero_we = 1'b1;
        zero_d  = (diff == '0);
      end
      OP_MVNZ: begin
        wr_en   = ~zero_q;
        wr_data = rs_val;
      end
      default: begin
        wr_en   = 1'b0;
        wr_data = '0;
      end
    endcase
  end

endmodule

// File: rtl/rfc_regfile.sv
module rfc_regfile
  import rfc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RIW-1:0]   rd_idx,
  input  logic [RIW-1:0]   rs_idx,
  output logic [DW-1:0]    rd_val,
  output logic [DW-1:0]    rs_val,
  input  logic             wr_en,
  input  logic [RIW-1:0]   wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    pc_q,
  output logic [DW-1:0]    pc_next,
  output logic [NREG*DW-1:0] dbg_regs
);

  localparam logic [RIW-1:0] PC_SEL = RIW'(PC_IDX);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] pc_seq;
  logic          pc_wr;

  always_comb begin
    pc_q    = regs[PC_IDX];
    pc_seq  = pc_q + DW'(1);
    pc_wr   = wr_en && (wr_idx == PC_SEL);
    pc_next = pc_wr ? wr_data : pc_seq;
    // R4: the counter register reads as the following address
    rd_val  = (rd_idx == PC_SEL) ? pc_seq : regs[rd_idx];
    rs_val  = (rs_idx == PC_SEL) ? pc_seq : regs[rs_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (i == PC_IDX)
          regs[i] <= pc_next;
        else if (wr_en && (wr_idx == RIW'(i)))
          regs[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_dbg
    assign dbg_regs[g*DW +: DW] = regs[g];
  end

  // R7: sequential advance when the counter is not a destination
  a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_idx == PC_SEL)) |=> pc_q == $past(pc_q) + DW'(1));

  // R7: a write to the counter redirects execution
  a_r7_pc_jump: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == PC_SEL)) |=> pc_q == $past(wr_data));

endmodule

// File: rtl/rfc_core.sv
module rfc_core
  import rfc_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic                clk,
  input  logic                rst,
  output logic [DW-1:0]       imem_addr,
  input  logic [IW-1:0]       imem_rdata,
  output logic [NREG*DW-1:0]  dbg_regs,
  output logic                dbg_zero
);

  fields_t       fld;
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rs_val;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          zero_we;
  logic          zero_d;
  logic          zero_q;
  logic [DW-1:0] pc_q;
  logic [DW-1:0] pc_next;

  rfc_decode #(.IW(IW), .DW(DW)) u_dec (
    .instr   (imem_rdata),
    .fld     (fld),
    .imm_ext (imm_ext)
  );

  rfc_regfile #(.DW(DW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (fld.rd),
    .rs_idx   (fld.rs),
    .rd_val   (rd_val),
    .rs_val   (rs_val),
    .wr_en    (wr_en),
    .wr_idx   (fld.rd),
    .wr_data  (wr_data),
    .pc_q     (pc_q),
    .pc_next  (pc_next),
    .dbg_regs (dbg_regs)
  );

  rfc_exec #(.DW(DW)) u_ex (
    .op      (fld.op),
    .rd_val  (rd_val),
    .rs_val  (rs_val),
    .imm_ext (imm_ext),
    .zero_q  (zero_q),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .zero_we (zero_we),
    .zero_d  (zero_d)
  );

  always_ff @(posedge clk) begin
    if (rst)          zero_q <= 1'b0;
    else if (zero_we) zero_q <= zero_d;
  end

  // R1, R8: fetch address is pinned to 0 in reset, else the next counter value
  assign imem_addr = rst ? '0 : pc_next;
  assign dbg_zero  = zero_q;

  // R8: the fetched address becomes the counter after the edge
  a_r8_fetch_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_q == $past(imem_addr));

  // R5: subtract leaves the flag equal to zero-ness of the stored difference
  a_r5_zero_set: assert property (@(posedge clk) disable iff (rst)
    (fld.op == OP_SUB) |=> zero_q == ($past(wr_data) == '0));

  // R5, R9: only subtract touches the flag
  a_r5_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (fld.op != OP_SUB) |=> $stable(zero_q));

  // R6: conditional copy is suppressed while the flag is set
  a_r6_mvnz_skip: assert property (@(posedge clk) disable iff (rst)
    (fld.op == OP_MVNZ && zero_q) |-> !wr_en);

  // R9: reserved opcodes never write a register
  a_r9_rsv_nowrite: assert property (@(posedge clk) disable iff (rst)
    (fld.op[2]) |-> !wr_en);

endmodule

// File: tb/rfc_core_tb_top.sv
module rfc_core_tb_top;

  localparam logic [2:0] MV = 3'd0, MVI = 3'd1, SUB = 3'd2, MVNZ = 3'd3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  imem_addr;
  logic [15:0]  imem_rdata;
  logic [127:0] dbg_regs;
  logic         dbg_zero;
  logic [15:0]  imem [64];
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) imem_rdata <= imem[imem_addr[5:0]];

  rfc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dbg_regs   (dbg_regs),
    .dbg_zero   (dbg_zero)
  );

  // R2 encoding: {opcode, d, s, imm7}
  function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] rd,
                                      input logic [2:0] rs, input logic [6:0] imm);
    return {op, rd, rs, imm};
  endfunction

  function automatic logic [15:0] rv(input int idx);
    return dbg_regs[idx*16 +: 16];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 64; a++) imem[a] = enc(3'd4, 3'd0, 3'd0, 7'd0);
  endtask

  // {req[39:36], reg[35:33], value[32:17], R7[16:1], zero[0]} after each executed step
  localparam logic [39:0] VEC [24] = '{
    {4'd3, 3'd1, 16'd5,     16'd1,  1'b0},  // R3 mvi R1,5
    {4'd3, 3'd2, 16'd3,     16'd2,  1'b0},  // R3 mvi R2,3
    {4'd5, 3'd1, 16'd2,     16'd3,  1'b0},  // R5 sub R1,R2
    {4'd4, 3'd3, 16'd2,     16'd4,  1'b0},  // R4 mv R3,R1
    {4'd5, 3'd2, 16'd0,     16'd5,  1'b1},  // R5 sub R2,R2 -> zero
    {4'd6, 3'd4, 16'd0,     16'd6,  1'b1},  // R6 mvnz skipped
    {4'd3, 3'd5, 16'd127,   16'd7,  1'b1},  // R3 largest immediate
    {4'd5, 3'd4, 16'hFF81,  16'd8,  1'b0},  // R5 wrapping difference
    {4'd6, 3'd6, 16'hFF81,  16'd9,  1'b0},  // R6 mvnz taken
    {4'd4, 3'd5, 16'd10,    16'd10, 1'b0},  // R4 mv R5,R7 reads next address
    {4'd9, 3'd6, 16'hFF81,  16'd11, 1'b0},  // R9 reserved opcode
    {4'd7, 3'd7, 16'd14,    16'd14, 1'b0},  // R7 mvi R7,14 jump
    {4'd7, 3'd1, 16'd9,     16'd15, 1'b0},  // R7 landed at 14
    {4'd3, 3'd2, 16'd1,     16'd16, 1'b0},
    {4'd3, 3'd3, 16'd3,     16'd17, 1'b0},
    {4'd4, 3'd4, 16'd18,    16'd18, 1'b0},  // R4 loop head saved
    {4'd5, 3'd3, 16'd2,     16'd19, 1'b0},
    {4'd7, 3'd3, 16'd2,     16'd18, 1'b0},  // R7 loop back
    {4'd5, 3'd3, 16'd1,     16'd19, 1'b0},
    {4'd7, 3'd3, 16'd1,     16'd18, 1'b0},
    {4'd5, 3'd3, 16'd0,     16'd19, 1'b1},
    {4'd6, 3'd3, 16'd0,     16'd20, 1'b1},  // R6 loop exit
    {4'd7, 3'd7, 16'd20,    16'd20, 1'b1},  // R7 self jump
    {4'd7, 3'd6, 16'hFF81,  16'd20, 1'b1}   // R7 skipped code never ran
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [39:0] e;
    string       tag;

    clear_mem();
    imem[0]  = enc(MVI,  3'd1, 3'd0, 7'd5);
    imem[1]  = enc(MVI,  3'd2, 3'd0, 7'd3);
    imem[2]  = enc(SUB,  3'd1, 3'd2, 7'd0);
    imem[3]  = enc(MV,   3'd3, 3'd1, 7'd0);
    imem[4]  = enc(SUB,  3'd2, 3'd2, 7'd0);
    imem[5]  = enc(MVNZ, 3'd4, 3'd1, 7'd0);
    imem[6]  = enc(MVI,  3'd5, 3'd0, 7'd127);
    imem[7]  = enc(SUB,  3'd4, 3'd5, 7'd0);
    imem[8]  = enc(MVNZ, 3'd6, 3'd4, 7'd0);
    imem[9]  = enc(MV,   3'd5, 3'd7, 7'd0);
    imem[10] = enc(3'd7, 3'd6, 3'd1, 7'd33);
    imem[11] = enc(MVI,  3'd7, 3'd0, 7'd14);
    imem[12] = enc(MVI,  3'd6, 3'd0, 7'd1);
    imem[13] = enc(MVI,  3'd6, 3'd0, 7'd2);
    imem[14] = enc(MVI,  3'd1, 3'd0, 7'd9);
    imem[15] = enc(MVI,  3'd2, 3'd0, 7'd1);
    imem[16] = enc(MVI,  3'd3, 3'd0, 7'd3);
    imem[17] = enc(MV,   3'd4, 3'd7, 7'd0);
    imem[18] = enc(SUB,  3'd3, 3'd2, 7'd0);
    imem[19] = enc(MVNZ, 3'd7, 3'd4, 7'd0);
    imem[20] = enc(MVI,  3'd7, 3'd0, 7'd20);

    repeat (3) @(negedge clk);
    // R1: reset state
    for (int r = 0; r < 8; r++) check("R1", $sformatf("reset reg%0d", r), rv(r), 16'd0);
    check("R1", "reset zero", {15'd0, dbg_zero}, 16'd0);
    check("R1", "reset fetch address", imem_addr, 16'd0);
    rst = 1'b0;

    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      e   = VEC[i];
      tag = $sformatf("R%0d", e[39:36]);
      check(tag, $sformatf("step %0d reg%0d", i, e[35:33]), rv(int'(e[35:33])), e[32:17]);
      check(tag, $sformatf("step %0d counter", i), rv(7), e[16:1]);
      check(tag, $sformatf("step %0d zero", i), {15'd0, dbg_zero}, {15'd0, e[0]});
    end
    // R8: self loop keeps fetching its own address
    check("R8", "fetch address in self loop", imem_addr, 16'd20);

    // Directed: reset mid-run, conditional copy after reset, subtract into R7
    rst = 1'b1;
    clear_mem();
    imem[0] = enc(MVI,  3'd1, 3'd0, 7'd6);
    imem[1] = enc(MVNZ, 3'd2, 3'd1, 7'd0);
    imem[2] = enc(MVI,  3'd3, 3'd0, 7'd1);
    imem[3] = enc(SUB,  3'd7, 3'd3, 7'd0);
    imem[4] = enc(MVI,  3'd4, 3'd0, 7'd55);
    @(negedge clk);
    check("R1", "rerest counter", rv(7), 16'd0);
    check("R1", "rerest reg1", rv(1), 16'd0);
    check("R1", "rerest zero", {15'd0, dbg_zero}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R3", "after-reset mvi", rv(1), 16'd6);
    @(negedge clk);
    check("R6", "mvnz with cleared flag", rv(2), 16'd6);
    @(negedge clk);
    check("R3", "mvi R3", rv(3), 16'd1);
    @(negedge clk);
    check("R7", "sub into counter (4-1)", rv(7), 16'd3);
    check("R5", "sub into counter flag", {15'd0, dbg_zero}, 16'd0);
    @(negedge clk);
    check("R7", "sub into counter repeats", rv(7), 16'd3);
    check("R8", "fetch address follows counter", imem_addr, 16'd3);
    check("R7", "code past loop not run", rv(4), 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule